// File: doc/BRIEF.md
# Page ownership table with inline access check

This block keeps one ownership record for every 4KB page of a small physical memory region and checks each guest memory access against that record. The host side can give a page to a guest address space with the host request port. This records the owning ASID, the guest page frame the page must appear at, and read/write permissions for each of four privilege levels. Every such assignment leaves the page not yet accepted. The guest then accepts the page through the validate port. Acceptance only succeeds when the guest's ASID and guest frame match the record.

Each memory access presents a system page frame, an ASID, a guest page frame, a privilege level, a write flag and a private/shared flag. The block answers one cycle later with pass or a 2-bit fault reason. Shared accesses are never checked against ownership.

The host can also reclaim a page, which returns it to the unowned state. A page assigned with the lock flag set refuses all later host changes until reset. All addresses on the ports are page frame numbers: the byte offset inside a page plays no part in the check.

Top module: `pgown_checker`

## Requirements
- R1: After reset every page is unowned, every response output is low, and a private access to any page returns fault code 1.
- R2: The host, validate and access responses each appear exactly one cycle after their request, and a response strobe is low in any cycle after a cycle with no request.
- R3: An access with the private flag low passes with code 0, whatever the page record holds.
- R4: A host assignment (host_assign=1) on an unlocked page records owner ASID, guest frame and permissions, responds with no error, and leaves the page not validated, so that a matching private access returns code 3.
- R5: A validate request succeeds (gv_rsp_ok=1) only when the page is assigned and both its ASID and guest frame match the record. Otherwise it fails and the record is unchanged.
- R6: A private access to a validated page, from the owner, at the recorded guest frame and with a permitted level and direction, passes with code 0.
- R7: A private access to an unassigned page, or one whose ASID differs from the owner, returns code 1. This takes priority over every other reason.
- R8: A private access from the owner at a guest frame other than the recorded one returns code 2. This takes priority over the not-validated and permission reasons.
- R9: Permission bit 2*L of host_perm allows reads at level L, and bit 2*L+1 allows writes at level L (level 0 is highest). A private access with the needed bit clear returns code 3.
- R10: A host request of either kind on a locked page responds with host_rsp_err=1 and leaves the record, including its validated state, unchanged.
- R11: A host assignment of an already validated page clears its validated state.
- R12: A host reclaim (host_assign=0) on an unlocked page makes it unowned. Later accesses return code 1, and later validates fail.
- R13: When a host request and a validate request name the same page in the same cycle, the host request takes effect and the validate reports failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request strobe |
| host_spfn | input | IDX_W | System page frame targeted by the host |
| host_assign | input | 1 | 1 assigns the page, 0 reclaims it |
| host_lock | input | 1 | Lock the page against later host changes |
| host_asid | input | 16 | Owner ASID to record |
| host_gfn | input | 20 | Guest page frame to record |
| host_perm | input | 8 | Per-level read/write permission bits |
| host_rsp | output | 1 | Host response strobe |
| host_rsp_err | output | 1 | Host request refused (page locked) |
| gv_req | input | 1 | Guest validate strobe |
| gv_spfn | input | IDX_W | System page frame to validate |
| gv_asid | input | 16 | ASID of the validating guest |
| gv_gfn | input | 20 | Guest frame the guest expects |
| gv_rsp | output | 1 | Validate response strobe |
| gv_rsp_ok | output | 1 | Validate succeeded |
| acc_req | input | 1 | Access check strobe |
| acc_spfn | input | IDX_W | System page frame accessed |
| acc_private | input | 1 | Access is private (checked) |
| acc_asid | input | 16 | Requesting ASID |
| acc_gfn | input | 20 | Guest frame used by the access |
| acc_lvl | input | 2 | Privilege level of the access |
| acc_write | input | 1 | Access is a write |
| chk_rsp | output | 1 | Check result strobe |
| chk_pass | output | 1 | Access allowed |
| chk_code | output | 2 | Fault reason: 0 none, 1 owner/ASID, 2 guest frame, 3 not validated or permission |

## Verification
Some properties are checked on every cycle. These are the one-cycle response timing, the pass of shared accesses, fault code 1 for unowned pages, the consistency of pass with a non-zero code, and several effects on the table. The table effects are: a successful validate leaves the page validated, a host assignment leaves it unvalidated, a locked page stays unchanged, and a validate that collides with a host request fails. The order of priority among fault reasons, the meaning of each permission bit, and the full assign-validate-reassign-reclaim sequence for a page depend on the history of a page. These show only in the bench's directed scenarios.

// File: rtl/pgown_pkg.sv
package pgown_pkg;

    localparam int unsigned ASID_W  = 16;
    // guest frame bits of a 32-bit guest address with 4KB pages
    localparam int unsigned GFN_W   = 20;
    localparam int unsigned NUM_LVL = 4;
    localparam int unsigned LVL_W   = $clog2(NUM_LVL);
    localparam int unsigned PERM_W  = 2 * NUM_LVL;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_OWNER  = 2'd1,
        FLT_GFRAME = 2'd2,
        FLT_ACCESS = 2'd3
    } fault_e;

    typedef struct packed {
        logic              assigned;
        logic              locked;
        logic              validated;
        logic [ASID_W-1:0] asid;
        logic [GFN_W-1:0]  gfn;
        logic [PERM_W-1:0] perm;
    } page_entry_t;

    // bit 2*lvl is read permission, bit 2*lvl+1 is write permission
    function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                         input logic [LVL_W-1:0]  lvl,
                                         input logic              wr);
        return perm[{lvl, wr}];
    endfunction

    function automatic fault_e classify(input page_entry_t       e,
                                        input logic              priv,
                                        input logic [ASID_W-1:0] asid,
                                        input logic [GFN_W-1:0]  gfn,
                                        input logic [LVL_W-1:0]  lvl,
                                        input logic              wr);
        fault_e f;
        if (!priv)
            f = FLT_NONE;
        else if (!e.assigned || (e.asid != asid))
            f = FLT_OWNER;
        else if (e.gfn != gfn)
            f = FLT_GFRAME;
        else if (!e.validated || !perm_allows(e.perm, lvl, wr))
            f = FLT_ACCESS;
        else
            f = FLT_NONE;
        return f;
    endfunction

endpackage

// File: rtl/pgown_table.sv
module pgown_table
    import pgown_pkg::*;
#(
    parameter  int unsigned NUM_PAGES = 16,
    localparam int unsigned IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_assign,
    input  logic              upd_lock,
    input  logic [ASID_W-1:0] upd_asid,
    input  logic [GFN_W-1:0]  upd_gfn,
    input  logic [PERM_W-1:0] upd_perm,
    output logic              upd_rsp,
    output logic              upd_rsp_err,
    input  logic              val_valid,
    input  logic [IDX_W-1:0]  val_idx,
    input  logic [ASID_W-1:0] val_asid,
    input  logic [GFN_W-1:0]  val_gfn,
    output logic              val_rsp,
    output logic              val_rsp_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output page_entry_t       rd_entry
);

    page_entry_t tbl [NUM_PAGES];

    logic upd_blocked;
    logic upd_fire;
    logic val_match;
    logic val_clash;
    logic val_fire;

    always_comb begin
        upd_blocked = tbl[upd_idx].locked;
        upd_fire    = upd_valid && !upd_blocked;
        val_match   = val_valid && tbl[val_idx].assigned
                      && (tbl[val_idx].asid == val_asid)
                      && (tbl[val_idx].gfn == val_gfn);
        val_clash   = upd_valid && (upd_idx == val_idx);
        val_fire    = val_match && !val_clash;
        rd_entry    = tbl[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PAGES; i++)
                tbl[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                if (upd_fire && (upd_idx == IDX_W'(i))) begin
                    if (upd_assign) begin
                        tbl[i].assigned  <= 1'b1;
                        tbl[i].locked    <= upd_lock;
                        tbl[i].validated <= 1'b0;
                        tbl[i].asid      <= upd_asid;
                        tbl[i].gfn       <= upd_gfn;
                        tbl[i].perm      <= upd_perm;
                    end else begin
                        tbl[i] <= '0;
                    end
                end else if (val_fire && (val_idx == IDX_W'(i))) begin
                    tbl[i].validated <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_rsp     <= 1'b0;
            upd_rsp_err <= 1'b0;
            val_rsp     <= 1'b0;
            val_rsp_ok  <= 1'b0;
        end else begin
            upd_rsp     <= upd_valid;
            upd_rsp_err <= upd_valid && upd_blocked;
            val_rsp     <= val_valid;
            val_rsp_ok  <= val_fire;
        end
    end

    // R5: a reported success leaves the page validated
    p_val_ok_sets_r5: assert property (@(posedge clk) disable iff (rst)
        val_rsp_ok |-> tbl[$past(val_idx)].validated);

    // R11: an accepted assignment leaves the page owned but unvalidated
    p_assign_invalid_r11: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_assign && !tbl[upd_idx].locked)
        |=> (tbl[$past(upd_idx)].assigned && !tbl[$past(upd_idx)].validated));

    // R10: a locked page refuses host changes and keeps its record
    p_locked_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && tbl[upd_idx].locked)
        |=> (upd_rsp_err && (tbl[$past(upd_idx)] == $past(tbl[upd_idx]))));

    // R13: host request wins over a validate to the same page
    p_clash_fails_r13: assert property (@(posedge clk) disable iff (rst)
        (val_valid && upd_valid && (val_idx == upd_idx)) |=> !val_rsp_ok);

    // R2: response strobes follow their requests by one cycle
    p_upd_latency_r2: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> upd_rsp);
    p_val_latency_r2: assert property (@(posedge clk) disable iff (rst)
        val_valid |=> val_rsp);

endmodule

// File: rtl/pgown_access_chk.sv
module pgown_access_chk
    import pgown_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_private,
    input  logic [ASID_W-1:0] acc_asid,
    input  logic [GFN_W-1:0]  acc_gfn,
    input  logic [LVL_W-1:0]  acc_lvl,
    input  logic              acc_write,
    input  page_entry_t       entry,
    output logic              res_valid,
    output logic              res_pass,
    output fault_e            res_code
);

    fault_e verdict;

    always_comb begin
        verdict = classify(entry, acc_private, acc_asid, acc_gfn, acc_lvl, acc_write);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_code  <= FLT_NONE;
        end else begin
            res_valid <= acc_valid;
            res_pass  <= acc_valid && (verdict == FLT_NONE);
            res_code  <= acc_valid ? verdict : FLT_NONE;
        end
    end

    // R2: one result per request, one cycle later
    p_acc_latency_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);
    p_acc_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    // R3: shared accesses always pass
    p_shared_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_private) |=> (res_pass && (res_code == FLT_NONE)));

    // R7: an unowned page faults with the owner reason
    p_unowned_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_private && !entry.assigned) |=> (res_code == FLT_OWNER));

    // R6: a failing result always carries a reason
    p_fault_has_code_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_pass) |-> (res_code != FLT_NONE));

endmodule

// File: rtl/pgown_checker.sv
module pgown_checker
    import pgown_pkg::*;
#(
    parameter  int unsigned NUM_PAGES = 16,
    localparam int unsigned IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_req,
    input  logic [IDX_W-1:0] host_spfn,
    input  logic             host_assign,
    input  logic             host_lock,
    input  logic [15:0]      host_asid,
    input  logic [19:0]      host_gfn,
    input  logic [7:0]       host_perm,
    output logic             host_rsp,
    output logic             host_rsp_err,
    input  logic             gv_req,
    input  logic [IDX_W-1:0] gv_spfn,
    input  logic [15:0]      gv_asid,
    input  logic [19:0]      gv_gfn,
    output logic             gv_rsp,
    output logic             gv_rsp_ok,
    input  logic             acc_req,
    input  logic [IDX_W-1:0] acc_spfn,
    input  logic             acc_private,
    input  logic [15:0]      acc_asid,
    input  logic [19:0]      acc_gfn,
    input  logic [1:0]       acc_lvl,
    input  logic             acc_write,
    output logic             chk_rsp,
    output logic             chk_pass,
    output logic [1:0]       chk_code
);

    page_entry_t acc_entry;
    fault_e      code_q;

    pgown_table #(.NUM_PAGES(NUM_PAGES)) u_table (
        .clk         (clk),
        .rst         (rst),
        .upd_valid   (host_req),
        .upd_idx     (host_spfn),
        .upd_assign  (host_assign),
        .upd_lock    (host_lock),
        .upd_asid    (host_asid),
        .upd_gfn     (host_gfn),
        .upd_perm    (host_perm),
        .upd_rsp     (host_rsp),
        .upd_rsp_err (host_rsp_err),
        .val_valid   (gv_req),
        .val_idx     (gv_spfn),
        .val_asid    (gv_asid),
        .val_gfn     (gv_gfn),
        .val_rsp     (gv_rsp),
        .val_rsp_ok  (gv_rsp_ok),
        .rd_idx      (acc_spfn),
        .rd_entry    (acc_entry)
    );

    pgown_access_chk u_chk (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_req),
        .acc_private (acc_private),
        .acc_asid    (acc_asid),
        .acc_gfn     (acc_gfn),
        .acc_lvl     (acc_lvl),
        .acc_write   (acc_write),
        .entry       (acc_entry),
        .res_valid   (chk_rsp),
        .res_pass    (chk_pass),
        .res_code    (code_q)
    );

    assign chk_code = code_q;

endmodule

// File: tb/pgown_checker_tb.sv
module pgown_checker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NPAGES     = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 0, host_assign = 0, host_lock = 0;
    logic [3:0]  host_spfn = '0;
    logic [15:0] host_asid = '0;
    logic [19:0] host_gfn = '0;
    logic [7:0]  host_perm = '0;
    logic        host_rsp, host_rsp_err;
    logic        gv_req = 0;
    logic [3:0]  gv_spfn = '0;
    logic [15:0] gv_asid = '0;
    logic [19:0] gv_gfn = '0;
    logic        gv_rsp, gv_rsp_ok;
    logic        acc_req = 0, acc_private = 0, acc_write = 0;
    logic [3:0]  acc_spfn = '0;
    logic [15:0] acc_asid = '0;
    logic [19:0] acc_gfn = '0;
    logic [1:0]  acc_lvl = '0;
    logic        chk_rsp, chk_pass;
    logic [1:0]  chk_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgown_checker #(.NUM_PAGES(NPAGES)) u_dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_spfn(host_spfn), .host_assign(host_assign),
        .host_lock(host_lock), .host_asid(host_asid), .host_gfn(host_gfn),
        .host_perm(host_perm), .host_rsp(host_rsp), .host_rsp_err(host_rsp_err),
        .gv_req(gv_req), .gv_spfn(gv_spfn), .gv_asid(gv_asid), .gv_gfn(gv_gfn),
        .gv_rsp(gv_rsp), .gv_rsp_ok(gv_rsp_ok),
        .acc_req(acc_req), .acc_spfn(acc_spfn), .acc_private(acc_private),
        .acc_asid(acc_asid), .acc_gfn(acc_gfn), .acc_lvl(acc_lvl),
        .acc_write(acc_write), .chk_rsp(chk_rsp), .chk_pass(chk_pass),
        .chk_code(chk_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_host(input logic [3:0] p, input logic asg, input logic lk,
                              input logic [15:0] a, input logic [19:0] g,
                              input logic [7:0] pm);
        host_req = 1; host_spfn = p; host_assign = asg; host_lock = lk;
        host_asid = a; host_gfn = g; host_perm = pm;
    endtask

    task automatic drive_val(input logic [3:0] p, input logic [15:0] a,
                             input logic [19:0] g);
        gv_req = 1; gv_spfn = p; gv_asid = a; gv_gfn = g;
    endtask

    task automatic do_host(input logic [3:0] p, input logic asg, input logic lk,
                           input logic [15:0] a, input logic [19:0] g,
                           input logic [7:0] pm, input int exp_err, input string req);
        @(negedge clk);
        drive_host(p, asg, lk, a, g, pm);
        @(negedge clk);
        host_req = 0;
        chk({req, " host strobe"}, int'(host_rsp), 1);
        chk({req, " host error"}, int'(host_rsp_err), exp_err);
    endtask

    task automatic do_val(input logic [3:0] p, input logic [15:0] a,
                          input logic [19:0] g, input int exp_ok, input string req);
        @(negedge clk);
        drive_val(p, a, g);
        @(negedge clk);
        gv_req = 0;
        chk({req, " validate ok"}, int'(gv_rsp_ok), exp_ok);
    endtask

    task automatic do_acc(input logic [3:0] p, input logic pv, input logic [15:0] a,
                          input logic [19:0] g, input logic [1:0] l, input logic w,
                          input int exp_code, input string req);
        @(negedge clk);
        acc_req = 1; acc_spfn = p; acc_private = pv; acc_asid = a;
        acc_gfn = g; acc_lvl = l; acc_write = w;
        @(negedge clk);
        acc_req = 0;
        chk({req, " R2 strobe"}, int'(chk_rsp), 1);
        chk({req, " code"}, int'(chk_code), exp_code);
        chk({req, " pass"}, int'(chk_pass), (exp_code == 0) ? 1 : 0);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 chk_rsp after reset", int'(chk_rsp), 0);
        chk("R1 host_rsp after reset", int'(host_rsp), 0);
        chk("R1 gv_rsp after reset", int'(gv_rsp), 0);
        do_acc(4'd3, 1, 16'd5, 20'h00003, 2'd0, 0, 1, "R1 unowned page");
        do_acc(4'd15, 1, 16'd0, 20'h0, 2'd0, 0, 1, "R1 unowned last page");
        @(negedge clk);
        chk("R2 idle strobe", int'(chk_rsp), 0);
    endtask

    task automatic t_shared();
        do_acc(4'd9, 0, 16'd5, 20'h0abcd, 2'd3, 1, 0, "R3 shared unowned");
    endtask

    task automatic t_assign_flow();
        do_host(4'd2, 1, 0, 16'd7, 20'h00123, 8'hff, 0, "R4 assign");
        do_acc(4'd2, 1, 16'd7, 20'h00123, 2'd0, 0, 3, "R4 before validate");
        do_val(4'd2, 16'd8, 20'h00123, 0, "R5 wrong asid");
        do_val(4'd2, 16'd7, 20'h00124, 0, "R5 wrong frame");
        do_acc(4'd2, 1, 16'd7, 20'h00123, 2'd0, 0, 3, "R5 unchanged");
        do_val(4'd8, 16'd7, 20'h00123, 0, "R5 unassigned page");
        do_val(4'd2, 16'd7, 20'h00123, 1, "R5 match");
        do_acc(4'd2, 1, 16'd7, 20'h00123, 2'd0, 1, 0, "R6 owner write");
        do_acc(4'd2, 0, 16'd9, 20'h00777, 2'd2, 0, 0, "R3 shared owned");
    endtask

    task automatic t_mismatch();
        do_acc(4'd2, 1, 16'd9, 20'h00123, 2'd0, 0, 1, "R7 other asid");
        do_acc(4'd2, 1, 16'd7, 20'h00124, 2'd0, 0, 2, "R8 other frame");
        do_acc(4'd2, 1, 16'd9, 20'h00124, 2'd0, 0, 1, "R7 priority over frame");
        do_host(4'd5, 1, 0, 16'd7, 20'h00050, 8'hff, 0, "R4 assign page5");
        do_acc(4'd5, 1, 16'd7, 20'h00051, 2'd0, 0, 2, "R8 priority over invalid");
    endtask

    task automatic t_perm();
        // L0 rw, L1 read only, L2 none, L3 write only
        do_host(4'd4, 1, 0, 16'd3, 20'h00040, 8'b10_00_01_11, 0, "R9 assign");
        do_val(4'd4, 16'd3, 20'h00040, 1, "R9 validate");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd0, 1, 0, "R9 L0 write");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd1, 0, 0, "R9 L1 read");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd1, 1, 3, "R9 L1 write");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd2, 0, 3, "R9 L2 read");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd3, 1, 0, "R9 L3 write");
        do_acc(4'd4, 1, 16'd3, 20'h00040, 2'd3, 0, 3, "R9 L3 read");
    endtask

    task automatic t_reassign_reclaim();
        do_host(4'd2, 1, 0, 16'd7, 20'h00123, 8'hff, 0, "R11 reassign");
        do_acc(4'd2, 1, 16'd7, 20'h00123, 2'd0, 0, 3, "R11 back to invalid");
        do_val(4'd2, 16'd7, 20'h00123, 1, "R11 revalidate");
        do_host(4'd2, 0, 0, 16'd0, 20'h0, 8'h00, 0, "R12 reclaim");
        do_acc(4'd2, 1, 16'd7, 20'h00123, 2'd0, 0, 1, "R12 after reclaim");
        do_val(4'd2, 16'd7, 20'h00123, 0, "R12 validate after reclaim");
    endtask

    task automatic t_locked();
        do_host(4'd6, 1, 1, 16'd1, 20'h00060, 8'hff, 0, "R10 locked assign");
        do_val(4'd6, 16'd1, 20'h00060, 1, "R10 validate");
        do_host(4'd6, 1, 0, 16'd2, 20'h00061, 8'h00, 1, "R10 reassign refused");
        do_acc(4'd6, 1, 16'd1, 20'h00060, 2'd2, 1, 0, "R10 record kept");
        do_host(4'd6, 0, 0, 16'd0, 20'h0, 8'h00, 1, "R10 reclaim refused");
        do_acc(4'd6, 1, 16'd1, 20'h00060, 2'd1, 0, 0, "R10 still valid");
    endtask

    task automatic t_clash();
        do_host(4'd7, 1, 0, 16'd4, 20'h00070, 8'hff, 0, "R13 setup");
        @(negedge clk);
        drive_host(4'd7, 1, 0, 16'd4, 20'h00070, 8'hff);
        drive_val(4'd7, 16'd4, 20'h00070);
        @(negedge clk);
        host_req = 0; gv_req = 0;
        chk("R13 validate loses", int'(gv_rsp_ok), 0);
        chk("R13 host accepted", int'(host_rsp_err), 0);
        do_acc(4'd7, 1, 16'd4, 20'h00070, 2'd0, 0, 3, "R13 page unvalidated");
    endtask

    initial begin
        t_reset();
        t_shared();
        t_assign_flow();
        t_mismatch();
        t_perm();
        t_reassign_reclaim();
        t_locked();
        t_clash();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule